// File: doc/BRIEF.md
# Two-Level Repeated-Block Address Generator

This block produces the source and destination byte addresses for one channel of a data mover that copies a block of bytes several times over. The transfer engine asks for addresses one beat at a time. Inside a burst, each beat moves the address up by the beat width. When a burst finishes, the next address is the byte just after that burst plus a signed burst jump. When a block finishes, the next address is the byte just after that block plus a signed block jump. At a block boundary the block jump is used instead of the burst jump, not added to it. The source and destination lanes each keep their own pair of jumps.

A `start` pulse in the idle state stores the whole configuration. The block then moves from `ST_IDLE` to `ST_RUN` (transition *launch*). On each cycle in `ST_RUN`, the engine pulses `step` to say that the beat at the current addresses has been done. The flags tell the engine whether that beat closes a burst, a block or the whole sequence. The `step` on the sequence's last beat moves the block back to `ST_IDLE` (transition *retire*). The other transitions hold the current state: *hold* keeps `ST_IDLE` when there is no `start`, and *advance* keeps `ST_RUN` on any beat that is not the last. The repeat count is given minus one, so 0 to 2047 means 1 to 2048 block passes.

Top module: `rblk_addr_gen`

## Requirements
- R1: A `start` while idle stores all configuration inputs and sets `busy` on the next edge. The first beat's `src_addr`/`dst_addr` equal `src_base`/`dst_base`.
- R2: A `step` on a beat that closes neither a burst nor a block moves each address up by BEAT_BYTES (4 by default).
- R3: A `step` on a beat that closes a burst but not a block sets each address to the old address + BEAT_BYTES + that lane's sign-extended burst offset (14-bit signed, -8191 to +8191). Zero gives contiguous bursts.
- R4: A `step` on a beat that closes a block but not the sequence sets each address to the old address + BEAT_BYTES + that lane's sign-extended block offset (17-bit signed, -65535 to +65535). The burst offset is not added at that step. The burst byte count restarts with the new block.
- R5: `burst_end` is high on a beat when the bytes left in the burst or the bytes left in the block are at most BEAT_BYTES. A burst cut short by a block end therefore closes together with the block, and `block_end` implies `burst_end`.
- R6: The sequence holds `rpt_m1`+1 blocks (up to 2048). `seq_end` is high only on the last beat of the last block. The `step` on that beat clears `busy` on the next edge and leaves the addresses at that beat's values.
- R7: Address arithmetic is 32-bit two's complement and wraps modulo 2^32 with no error indication.
- R8: A `start` while `busy` is ignored. The running sequence's addresses and flags continue unchanged.
- R9: A `step` while idle is ignored. The addresses hold, and `burst_end`, `block_end` and `seq_end` stay low.
- R10: After reset, `busy`, both addresses and all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load configuration and begin (idle only) |
| src_base | input | 32 | First source byte address |
| dst_base | input | 32 | First destination byte address |
| blk_bytes | input | 16 | Block length in bytes, a nonzero multiple of BEAT_BYTES |
| burst_bytes | input | 16 | Burst length in bytes, a nonzero multiple of BEAT_BYTES |
| rpt_m1 | input | 11 | Number of block passes minus one |
| src_burst_ofs | input | 14 | Signed source jump after a burst |
| dst_burst_ofs | input | 14 | Signed destination jump after a burst |
| src_blk_ofs | input | 17 | Signed source jump after a block |
| dst_blk_ofs | input | 17 | Signed destination jump after a block |
| step | input | 1 | Current beat has been done |
| busy | output | 1 | Sequence in progress (`ST_RUN`) |
| src_addr | output | 32 | Current source byte address |
| dst_addr | output | 32 | Current destination byte address |
| burst_end | output | 1 | Current beat closes a burst |
| block_end | output | 1 | Current beat closes a block |
| seq_end | output | 1 | Current beat closes the sequence |

## Verification
The three flags are combinational from the held counters, so they are valid in the same cycle as the beat they describe. The addresses move on the first clock edge that samples `step`. `busy` rises on the edge after `start` and falls on the edge after the final `step`. The bench drives inputs and reads outputs only at falling edges, so each beat's addresses and flags are compared half a cycle after the edge that produced them. A reference model in the bench, updated at every `step`, tracks the byte counts, repeat count and jumps over a sweep of block lengths, burst lengths, repeat counts and offsets, including the extreme offsets, the 2048-pass case and a run that wraps past 2^32.

// File: rtl/rblk_pkg.sv
package rblk_pkg;

    // Sequencer states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rblk_state_e;

    // Which jump applies at the next step
    typedef enum logic [1:0] {
        ADV_BEAT  = 2'd0,
        ADV_BURST = 2'd1,
        ADV_BLOCK = 2'd2
    } rblk_adv_e;

endpackage

// File: rtl/rblk_addr_lane.sv
module rblk_addr_lane
    import rblk_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BOW        = 14,
    parameter int KOW        = 17,
    parameter int BEAT_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  adv,
    input  rblk_adv_e             kind,
    input  logic [AW-1:0]         base,
    input  logic signed [BOW-1:0] burst_ofs,
    input  logic signed [KOW-1:0] blk_ofs,
    output logic [AW-1:0]         addr
);

    localparam logic [AW-1:0] BEAT_A = AW'(BEAT_BYTES);

    logic signed [BOW-1:0] burst_q;
    logic signed [KOW-1:0] blk_q;
    logic [AW-1:0]         jump;
    logic [AW-1:0]         addr_nx;

    // The block jump replaces the burst jump at a block boundary
    always_comb begin
        unique case (kind)
            ADV_BURST: jump = {{(AW-BOW){burst_q[BOW-1]}}, burst_q};
            ADV_BLOCK: jump = {{(AW-KOW){blk_q[KOW-1]}}, blk_q};
            default:   jump = '0;
        endcase
        addr_nx = addr + BEAT_A + jump;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            burst_q <= '0;
            blk_q   <= '0;
        end else if (load) begin
            addr    <= base;
            burst_q <= burst_ofs;
            blk_q   <= blk_ofs;
        end else if (adv) begin
            addr    <= addr_nx;
        end
    end

    // R2
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && kind == ADV_BEAT) |=> (addr == $past(addr) + BEAT_A));

    // R9
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(addr));

endmodule

// File: rtl/rblk_seq_ctr.sv
module rblk_seq_ctr
    import rblk_pkg::*;
#(
    parameter int CW         = 16,
    parameter int BW         = 16,
    parameter int RW         = 11,
    parameter int BEAT_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [CW-1:0] blk_bytes,
    input  logic [BW-1:0] burst_bytes,
    input  logic [RW-1:0] rpt_m1,
    output rblk_adv_e     kind,
    output logic          end_burst,
    output logic          end_block,
    output logic          end_seq
);

    localparam logic [CW-1:0] BEAT_C = CW'(BEAT_BYTES);
    localparam logic [BW-1:0] BEAT_B = BW'(BEAT_BYTES);

    logic [CW-1:0] blk_cfg, blk_left;
    logic [BW-1:0] burst_cfg, burst_left;
    logic [RW-1:0] rep_left;

    always_comb begin
        end_block = (blk_left <= BEAT_C);
        end_burst = end_block || (burst_left <= BEAT_B);
        end_seq   = end_block && (rep_left == '0);
        if (end_block)      kind = ADV_BLOCK;
        else if (end_burst) kind = ADV_BURST;
        else                kind = ADV_BEAT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_cfg    <= '0;
            burst_cfg  <= '0;
            blk_left   <= '0;
            burst_left <= '0;
            rep_left   <= '0;
        end else if (load) begin
            blk_cfg    <= blk_bytes;
            burst_cfg  <= burst_bytes;
            blk_left   <= blk_bytes;
            burst_left <= burst_bytes;
            rep_left   <= rpt_m1;
        end else if (adv && !end_seq) begin
            if (end_block) begin
                blk_left   <= blk_cfg;
                burst_left <= burst_cfg;
                rep_left   <= rep_left - 1'b1;
            end else begin
                blk_left   <= blk_left - BEAT_C;
                burst_left <= end_burst ? burst_cfg : (burst_left - BEAT_B);
            end
        end
    end

    // R6
    rep_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && end_block && !end_seq) |=> (rep_left == $past(rep_left) - 1'b1));

    // R4
    burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && end_block && !end_seq) |=> (burst_left == burst_cfg));

endmodule

// File: rtl/rblk_addr_gen.sv
module rblk_addr_gen
    import rblk_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 16,
    parameter int BW         = 16,
    parameter int RW         = 11,
    parameter int BOW        = 14,
    parameter int KOW        = 17,
    parameter int BEAT_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [AW-1:0]         src_base,
    input  logic [AW-1:0]         dst_base,
    input  logic [CW-1:0]         blk_bytes,
    input  logic [BW-1:0]         burst_bytes,
    input  logic [RW-1:0]         rpt_m1,
    input  logic signed [BOW-1:0] src_burst_ofs,
    input  logic signed [BOW-1:0] dst_burst_ofs,
    input  logic signed [KOW-1:0] src_blk_ofs,
    input  logic signed [KOW-1:0] dst_blk_ofs,
    input  logic                  step,
    output logic                  busy,
    output logic [AW-1:0]         src_addr,
    output logic [AW-1:0]         dst_addr,
    output logic                  burst_end,
    output logic                  block_end,
    output logic                  seq_end
);

    localparam int LANES = 2;

    rblk_state_e state, state_nx;
    rblk_adv_e   kind;
    logic        c_end_burst, c_end_block, c_end_seq;
    logic        load, adv;

    logic [LANES-1:0][AW-1:0]  lane_base;
    logic [LANES-1:0][BOW-1:0] lane_bofs;
    logic [LANES-1:0][KOW-1:0] lane_kofs;
    logic [LANES-1:0][AW-1:0]  lane_addr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: hold, launch, advance, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)             state_nx = ST_RUN;
            ST_RUN:  if (step && c_end_seq) state_nx = ST_IDLE;
            default:                        state_nx = ST_IDLE;
        endcase
    end

    // Outputs and strobes
    always_comb begin
        busy      = (state == ST_RUN);
        load      = (state == ST_IDLE) && start;
        adv       = busy && step;
        burst_end = busy && c_end_burst;
        block_end = busy && c_end_block;
        seq_end   = busy && c_end_seq;
    end

    assign lane_base = {dst_base, src_base};
    assign lane_bofs = {dst_burst_ofs, src_burst_ofs};
    assign lane_kofs = {dst_blk_ofs, src_blk_ofs};
    assign src_addr  = lane_addr[0];
    assign dst_addr  = lane_addr[1];

    rblk_seq_ctr #(
        .CW(CW), .BW(BW), .RW(RW), .BEAT_BYTES(BEAT_BYTES)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .adv        (adv),
        .blk_bytes  (blk_bytes),
        .burst_bytes(burst_bytes),
        .rpt_m1     (rpt_m1),
        .kind       (kind),
        .end_burst  (c_end_burst),
        .end_block  (c_end_block),
        .end_seq    (c_end_seq)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rblk_addr_lane #(
            .AW(AW), .BOW(BOW), .KOW(KOW), .BEAT_BYTES(BEAT_BYTES)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .adv      (adv && !c_end_seq),
            .kind     (kind),
            .base     (lane_base[g]),
            .burst_ofs(lane_bofs[g]),
            .blk_ofs  (lane_kofs[g]),
            .addr     (lane_addr[g])
        );
    end

    // R1
    launch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && src_addr == $past(src_base) && dst_addr == $past(dst_base)));

    // R5
    flag_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_end |-> burst_end) and (seq_end |-> block_end));

    // R6
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end && step) |=> (!busy && $stable(src_addr) && $stable(dst_addr)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(src_addr) && $stable(dst_addr) && !burst_end && !seq_end));

endmodule

// File: tb/sim_rblk_addr_gen.sv
`timescale 1ns/100ps
module sim_rblk_addr_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic               start = 1'b0, step = 1'b0;
    logic [31:0]        src_base = '0, dst_base = '0;
    logic [15:0]        blk_bytes = '0, burst_bytes = '0;
    logic [10:0]        rpt_m1 = '0;
    logic signed [13:0] src_burst_ofs = '0, dst_burst_ofs = '0;
    logic signed [16:0] src_blk_ofs = '0, dst_blk_ofs = '0;
    logic               busy, burst_end, block_end, seq_end;
    logic [31:0]        src_addr, dst_addr;

    rblk_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .blk_bytes(blk_bytes), .burst_bytes(burst_bytes), .rpt_m1(rpt_m1),
        .src_burst_ofs(src_burst_ofs), .dst_burst_ofs(dst_burst_ofs),
        .src_blk_ofs(src_blk_ofs), .dst_blk_ofs(dst_blk_ofs),
        .step(step), .busy(busy), .src_addr(src_addr), .dst_addr(dst_addr),
        .burst_end(burst_end), .block_end(block_end), .seq_end(seq_end)
    );

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One full sequence against an arithmetic model; optional start injected mid-run
    task automatic run_seq(input logic [31:0] sb, input logic [31:0] db,
                           input int blk, input int brst, input int rm1,
                           input int sbo, input int dbo, input int sko, input int dko,
                           input bit poke_start, input string wtag);
        logic [31:0] es, ed;
        int  bl, bu, rp, beat;
        bit  e_bu, e_bl, e_sq;
        string tag;
        @(negedge clk);
        src_base = sb; dst_base = db; blk_bytes = 16'(blk); burst_bytes = 16'(brst);
        rpt_m1 = 11'(rm1); src_burst_ofs = 14'(sbo); dst_burst_ofs = 14'(dbo);
        src_blk_ofs = 17'(sko); dst_blk_ofs = 17'(dko);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy", 32'(busy), 32'd1);
        es = sb; ed = db; bl = blk; bu = brst; rp = rm1; beat = 0; tag = "R1";
        forever begin
            e_bl = (bl <= 4);
            e_bu = e_bl || (bu <= 4);
            e_sq = e_bl && (rp == 0);
            chk(src_addr == es, {tag, wtag, " src"}, src_addr, es);
            chk(dst_addr == ed, {tag, wtag, " dst"}, dst_addr, ed);
            chk(burst_end == e_bu, "R5 burst_end", 32'(burst_end), 32'(e_bu));
            chk(block_end == e_bl, "R4 block_end", 32'(block_end), 32'(e_bl));
            chk(seq_end == e_sq, "R6 seq_end", 32'(seq_end), 32'(e_sq));
            step = 1'b1;
            if (poke_start && beat == 1) begin
                start = 1'b1; src_base = 32'hDEAD_0000; dst_base = 32'hBEEF_0000;
                src_burst_ofs = 14'sd100; src_blk_ofs = 17'sd1000; blk_bytes = 16'd64;
            end
            @(negedge clk);
            start = 1'b0;
            if (poke_start && beat == 1) tag = "R8";
            beat++;
            if (e_sq) break;
            if (e_bl) begin
                es = es + 32'd4 + 32'(sko); ed = ed + 32'd4 + 32'(dko);
                bl = blk; bu = brst; rp--; if (!poke_start || beat != 2) tag = "R4";
            end else if (e_bu) begin
                es = es + 32'd4 + 32'(sbo); ed = ed + 32'd4 + 32'(dbo);
                bu = brst; bl -= 4; if (!poke_start || beat != 2) tag = "R3";
            end else begin
                es = es + 32'd4; ed = ed + 32'd4;
                bu -= 4; bl -= 4; if (!poke_start || beat != 2) tag = "R2";
            end
        end
        step = 1'b0;
        chk(busy == 1'b0, "R6 busy after last", 32'(busy), 32'd0);
        chk(src_addr == es, "R6 src hold", src_addr, es);
        chk(beat == (rm1 + 1) * (blk / 4), "R6 beat count", 32'(beat), 32'((rm1 + 1) * (blk / 4)));
        // R9: steps while idle change nothing
        step = 1'b1;
        repeat (3) @(negedge clk);
        step = 1'b0;
        chk(src_addr == es && dst_addr == ed, "R9 idle src/dst", src_addr, es);
        chk(!burst_end && !block_end && !seq_end && !busy, "R9 idle flags",
            {28'd0, busy, burst_end, block_end, seq_end}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int blks[4]  = '{4, 8, 12, 20};
        int brsts[3] = '{4, 8, 12};
        int rms[2]   = '{0, 2};
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0, "R10 busy", 32'(busy), 32'd0);
        chk(src_addr == 32'd0 && dst_addr == 32'd0, "R10 addr", src_addr | dst_addr, 32'd0);
        chk(!burst_end && !block_end && !seq_end, "R10 flags",
            {29'd0, burst_end, block_end, seq_end}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 3; b++)
                for (int r = 0; r < 2; r++) begin
                    run_seq(32'h1000_0000, 32'h2000_0000, blks[a], brsts[b], rms[r], 0, 0, 0, 0, 0, "");
                    run_seq(32'h3000_1000, 32'h4000_8000, blks[a], brsts[b], rms[r], 16, -8, 100, -64, 0, "");
                    run_seq(32'h5000_0000, 32'h6000_0000, blks[a], brsts[b], rms[r],
                            -8191, 8191, -65535, 65535, 0, "");
                end
        // R7 wrap past 2^32 in both directions
        run_seq(32'hFFFF_FFF0, 32'h0000_0008, 16, 8, 2, 8191, -8191, 65535, -65535, 0, " R7");
        // R8 start while busy is ignored
        run_seq(32'h0000_4000, 32'h0000_8000, 20, 8, 1, 12, -4, 40, -200, 1, "");
        // R6 maximum repeat count, 2048 passes
        run_seq(32'h7000_0000, 32'h7100_0000, 4, 4, 2047, 0, 0, 4, -4, 0, "");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule